// File: doc/BRIEF.md
# Rotating Register File

This block is a small register file for loops whose iterations overlap in time. Every access names a register by a signed offset from a rotation base kept inside the block, not by a fixed physical index. At the end of each iteration the loop control pulses a rotate strobe. The base then moves down by one, and every logical name shifts by one position. A value that an iteration wrote at offset -1 is read at offset 0 by the next iteration, and no copy operation is needed.

Only a fixed window of logical names is backed by storage. That window is the physical file of `DEPTH` entries, where `DEPTH` is a power of two. Offsets past either end of the window wrap around modulo the file size. There are two combinational read ports and one write port, and all three take offsets. A clear input puts the base back to zero before a new loop starts.

Top module: `rotreg_file`

## Requirements
- R1: After a synchronous reset the rotation base is zero and every physical entry holds zero.
- R2: A port's physical index is (offset + base) modulo `DEPTH`, where the offset is an `OFS_W`-bit two's-complement number and the base is an unsigned `IDX_W`-bit value.
- R3: A cycle with `rotate` high and `base_clr` low decrements the base by one modulo `DEPTH` (0 becomes `DEPTH`-1). After that cycle, a value written at offset k is read at offset k+1.
- R4: Reads and the write in the same cycle as a rotate use the base from before the rotate. The new base applies from the next cycle.
- R5: `base_clr` high sets the base to zero at the next edge. It takes priority over `rotate` in the same cycle.
- R6: With `wr_en` high, `wr_data` is stored at the mapped entry at the clock edge. With `wr_en` low, no entry changes.
- R7: A read of the entry being written in the same cycle returns the old contents. The new value is visible from the next cycle.
- R8: The two read ports are independent. Both may address the same entry, and then both return the same data.
- R9: Offsets wrap in both directions. An offset of -`DEPTH`/2 and an offset that sends the sum past `DEPTH`-1 each alias to the entry that the modulo mapping gives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd0_ofs | input | OFS_W | Read port 0 signed logical offset |
| rd0_data | output | WIDTH | Read port 0 data (combinational) |
| rd1_ofs | input | OFS_W | Read port 1 signed logical offset |
| rd1_data | output | WIDTH | Read port 1 data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_ofs | input | OFS_W | Write port signed logical offset |
| wr_data | input | WIDTH | Write data |
| rotate | input | 1 | Rotate strobe; decrements the base at the edge |
| base_clr | input | 1 | Resets the base to zero at the edge |

## Verification
A rotate, a write and reads can all fall in one cycle, and a write can also collide with a read of the same physical entry. The bench creates both cases deliberately. It writes at offset -1 while rotating and reads offset 0 in the same cycle, then reads offset 0 in the next cycle. It also writes and reads one offset together. A behavioural model applies the write and the rotation only after the cycle's reads, and every read port is compared against it on every clock. The physical entries are first filled with distinct values, so that any error in the base or in the order of these operations shows up as a wrong read.

// File: rtl/rotreg_pkg.sv
package rotreg_pkg;

    // Base update selected for one clock edge
    typedef enum logic [1:0] {
        BASE_HOLD = 2'd0,
        BASE_STEP = 2'd1,
        BASE_ZERO = 2'd2
    } base_op_e;

    // A clear takes priority over a rotate issued in the same cycle
    function automatic base_op_e base_op(input logic clr, input logic rot);
        if (clr)      return BASE_ZERO;
        else if (rot) return BASE_STEP;
        else          return BASE_HOLD;
    endfunction

    // Width of the base and physical index for a given file size
    function automatic int idx_width(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/rotreg_base.sv
module rotreg_base
    import rotreg_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rotate,
    input  logic             clr,
    output logic [IDX_W-1:0] base
);

    base_op_e         op;
    logic [IDX_W-1:0] base_q;
    logic [IDX_W-1:0] base_d;

    assign op = base_op(clr, rotate);

    always_comb begin
        unique case (op)
            BASE_ZERO: base_d = '0;
            BASE_STEP: base_d = base_q - 1'b1;   // wraps naturally modulo 2**IDX_W
            default:   base_d = base_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) base_q <= '0;
        else     base_q <= base_d;
    end

    assign base = base_q;

endmodule

// File: rtl/rotreg_map.sv
module rotreg_map #(
    parameter int OFS_W = 5,
    parameter int IDX_W = 4
) (
    input  logic signed [OFS_W-1:0] ofs,
    input  logic        [IDX_W-1:0] base,
    output logic        [IDX_W-1:0] idx
);

    localparam int SUM_W = ((OFS_W > IDX_W) ? OFS_W : IDX_W) + 1;

    logic signed [SUM_W-1:0] ofs_ext;
    logic signed [SUM_W-1:0] base_ext;
    logic signed [SUM_W-1:0] sum;

    assign ofs_ext  = SUM_W'(ofs);
    assign base_ext = $signed({{(SUM_W-IDX_W){1'b0}}, base});
    assign sum      = ofs_ext + base_ext;
    // Power-of-two file: the low bits are the sum modulo DEPTH in both directions
    assign idx      = sum[IDX_W-1:0];

endmodule

// File: rtl/rotreg_store.sv
module rotreg_store #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    parameter int NRD   = 2,
    localparam int IDX_W = rotreg_pkg::idx_width(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx  [NRD],
    output logic [WIDTH-1:0] rd_data [NRD]
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Reads see the array before this cycle's write lands
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p] = mem[rd_idx[p]];
    end

endmodule

// File: rtl/rotreg_file.sv
module rotreg_file #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    parameter int OFS_W = 5,
    localparam int IDX_W = rotreg_pkg::idx_width(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [OFS_W-1:0] rd0_ofs,
    output logic        [WIDTH-1:0] rd0_data,
    input  logic signed [OFS_W-1:0] rd1_ofs,
    output logic        [WIDTH-1:0] rd1_data,
    input  logic                    wr_en,
    input  logic signed [OFS_W-1:0] wr_ofs,
    input  logic        [WIDTH-1:0] wr_data,
    input  logic                    rotate,
    input  logic                    base_clr
);

    localparam int NRD = 2;

    logic [IDX_W-1:0]        rrb;
    logic signed [OFS_W-1:0] rd_ofs  [NRD];
    logic [IDX_W-1:0]        rd_idx  [NRD];
    logic [WIDTH-1:0]        rd_data [NRD];
    logic [IDX_W-1:0]        wr_idx;

    rotreg_base #(.IDX_W(IDX_W)) u_base (
        .clk    (clk),
        .rst    (rst),
        .rotate (rotate),
        .clr    (base_clr),
        .base   (rrb)
    );

    assign rd_ofs[0] = rd0_ofs;
    assign rd_ofs[1] = rd1_ofs;

    for (genvar p = 0; p < NRD; p++) begin : g_rdmap
        rotreg_map #(.OFS_W(OFS_W), .IDX_W(IDX_W)) u_map (
            .ofs  (rd_ofs[p]),
            .base (rrb),
            .idx  (rd_idx[p])
        );
    end

    rotreg_map #(.OFS_W(OFS_W), .IDX_W(IDX_W)) u_wmap (
        .ofs  (wr_ofs),
        .base (rrb),
        .idx  (wr_idx)
    );

    rotreg_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .NRD(NRD)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    assign rd0_data = rd_data[0];
    assign rd1_data = rd_data[1];

endmodule

// File: rtl/rotreg_file_chk.sv
module rotreg_file_chk #(
    parameter int WIDTH = 32,
    parameter int OFS_W = 5,
    parameter int IDX_W = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic signed [OFS_W-1:0] rd0_ofs,
    input logic        [WIDTH-1:0] rd0_data,
    input logic signed [OFS_W-1:0] rd1_ofs,
    input logic        [WIDTH-1:0] rd1_data,
    input logic                    wr_en,
    input logic signed [OFS_W-1:0] wr_ofs,
    input logic        [WIDTH-1:0] wr_data,
    input logic                    rotate,
    input logic                    base_clr,
    input logic        [IDX_W-1:0] base
);

    // R3: a rotate without a clear moves the base down by one, with wrap
    p_base_step_r3: assert property (@(posedge clk) disable iff (rst)
        (rotate && !base_clr) |=> (base == IDX_W'($past(base) - 1'b1)));

    // R4: with neither rotate nor clear, the base stays where it is
    p_base_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!rotate && !base_clr) |=> $stable(base));

    // R5: a clear wins over a rotate and zeroes the base
    p_base_clear_r5: assert property (@(posedge clk) disable iff (rst)
        base_clr |=> (base == '0));

    // R6 / R7: a written value is visible at the same offset on the next cycle
    p_write_visible_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rotate && !base_clr) |=>
            ((rd0_ofs != $past(wr_ofs)) || (rd0_data == $past(wr_data))));

    // R8: both read ports agree when they name the same offset
    p_ports_agree_r8: assert property (@(posedge clk) disable iff (rst)
        (rd0_ofs == rd1_ofs) |-> (rd0_data == rd1_data));

endmodule

bind rotreg_file rotreg_file_chk #(
    .WIDTH (WIDTH),
    .OFS_W (OFS_W),
    .IDX_W (IDX_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd0_ofs  (rd0_ofs),
    .rd0_data (rd0_data),
    .rd1_ofs  (rd1_ofs),
    .rd1_data (rd1_data),
    .wr_en    (wr_en),
    .wr_ofs   (wr_ofs),
    .wr_data  (wr_data),
    .rotate   (rotate),
    .base_clr (base_clr),
    .base     (rrb)
);

// File: tb/rotreg_file_tb.sv
module rotreg_file_tb;

    localparam int WIDTH = 32;
    localparam int DEPTH = 16;
    localparam int OFS_W = 5;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic signed [OFS_W-1:0] rd0_ofs = '0;
    logic signed [OFS_W-1:0] rd1_ofs = '0;
    logic        [WIDTH-1:0] rd0_data;
    logic        [WIDTH-1:0] rd1_data;
    logic                    wr_en = 1'b0;
    logic signed [OFS_W-1:0] wr_ofs = '0;
    logic        [WIDTH-1:0] wr_data = '0;
    logic                    rotate = 1'b0;
    logic                    base_clr = 1'b0;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // Behavioural reference state
    int unsigned model_mem [DEPTH];
    int          model_base;

    always #4 clk = ~clk;   // 8 ns period

    rotreg_file #(.WIDTH(WIDTH), .DEPTH(DEPTH), .OFS_W(OFS_W)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .rd0_ofs  (rd0_ofs),
        .rd0_data (rd0_data),
        .rd1_ofs  (rd1_ofs),
        .rd1_data (rd1_data),
        .wr_en    (wr_en),
        .wr_ofs   (wr_ofs),
        .wr_data  (wr_data),
        .rotate   (rotate),
        .base_clr (base_clr)
    );

    function automatic int phys(input int ofs);
        return (((ofs + model_base) % DEPTH) + DEPTH) % DEPTH;
    endfunction

    task automatic check(input string req, input logic [WIDTH-1:0] act,
                         input logic [WIDTH-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("[TB] FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: drive at the negedge, compare reads, then update the model after the edge
    task automatic step(input string req, input bit we, input int wo, input int wd,
                        input int r0, input int r1, input bit rot, input bit clr);
        wr_en    = we;
        wr_ofs   = OFS_W'(wo);
        wr_data  = WIDTH'(wd);
        rd0_ofs  = OFS_W'(r0);
        rd1_ofs  = OFS_W'(r1);
        rotate   = rot;
        base_clr = clr;
        #2;
        check(req, rd0_data, model_mem[phys(r0)]);
        check(req, rd1_data, model_mem[phys(r1)]);
        @(posedge clk);
        if (we) model_mem[phys(wo)] = wd;
        if (clr)      model_base = 0;
        else if (rot) model_base = (model_base + DEPTH - 1) % DEPTH;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("[TB] FAIL watchdog actual=running expected=finished");
        if (!done) begin
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model_mem[i] = 0;
        model_base = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset contents and zero base
        step("R1", 0, 0, 0, 0, 5, 0, 0);
        step("R1", 0, 0, 0, -1, 15, 0, 0);

        // R2: fill physical entries with distinct values while base is zero
        for (int i = 0; i < DEPTH; i++) step("R2", 1, i, 'h100 + i, i, 0, 0, 0);
        for (int i = -16; i < 16; i += 3) step("R2", 0, 0, 0, i, -i - 1, 0, 0);

        // R9: extreme offsets alias in both directions
        step("R9", 0, 0, 0, -16, 15, 0, 0);
        step("R9", 0, 0, 0, -1, 0, 1, 0);      // rotate 0 -> DEPTH-1 (R3 wrap)
        step("R9", 0, 0, 0, 1, 0, 0, 0);
        step("R9", 0, 0, 0, 15, -16, 0, 0);

        // R3: write at -1, rotate, read at 0
        step("R3", 1, -1, 'hCAFE_0001, -1, 0, 0, 0);
        step("R3", 0, 0, 0, -1, -1, 1, 0);
        step("R3", 0, 0, 0, 0, 1, 0, 0);

        // R4: write and reads in the rotate cycle use the old base
        step("R4", 1, -1, 'hBEEF_0002, 0, -1, 1, 0);
        step("R4", 0, 0, 0, 0, 1, 0, 0);
        step("R4", 1, 2, 'h0000_7777, 2, 3, 1, 0);
        step("R4", 0, 0, 0, 3, 2, 0, 0);

        // R7: read of the entry under write shows the old value first
        step("R7", 1, 4, 'h1234_5678, 4, 4, 0, 0);
        step("R7", 0, 0, 0, 4, 4, 0, 0);

        // R6: disabled write leaves the entry alone
        step("R6", 0, 6, 'hDEAD_DEAD, 6, 6, 0, 0);
        step("R6", 0, 0, 0, 6, 6, 0, 0);

        // R5: clear beats rotate, then reads reflect base zero
        step("R5", 0, 0, 0, 0, 7, 1, 1);
        step("R5", 0, 0, 0, 0, 7, 0, 0);
        step("R5", 0, 0, 0, 1, 0, 0, 1);
        step("R5", 0, 0, 0, 0, -1, 0, 0);

        // R8: both ports on the same and on different entries
        step("R8", 0, 0, 0, 9, 9, 0, 0);
        step("R8", 0, 0, 0, -3, 12, 0, 0);

        // R2 / R4 / R7: mixed random traffic, compared every cycle
        for (int n = 0; n < 600; n++) begin
            step("R2", $urandom_range(0, 1) == 1, $urandom_range(0, 31) - 16, $urandom,
                 $urandom_range(0, 31) - 16, $urandom_range(0, 31) - 16,
                 $urandom_range(0, 2) == 0, $urandom_range(0, 15) == 0);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule